// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides whether an incoming Ethernet frame is kept. It reads the six destination-address bytes from a byte stream, in the order they leave the wire. It compares the address with a small table of exact addresses. In the same pass it computes a multicast bin index from the address and looks that bin up in a hash bit table. One clock after the last address byte it gives a decision: the frame is accepted or dropped, and a code says why it passed. Any later bytes of the frame are not used until the next start-of-frame.

Static control inputs select the filtering policy:
- promiscuous;
- pass every group address;
- hash filtering of group addresses;
- hash-or-perfect combining;
- receive-all;
- broadcast drop.

A 32-bit word write port loads the exact-match entries and the hash words. The parameter `HASH_BITS` (6, 7 or 8) sets the table to 64, 128 or 256 bins, held in 2, 4 or 8 words.

The byte input is a valid/ready stream. `s_ready` is always high, so the filter never applies back-pressure. A byte is taken in every cycle where `s_valid` is high, and gaps with `s_valid` low are allowed anywhere in the address.

Top module: `rx_addr_filter`

## Requirements
- R1: `dec_hash_idx` equals the top `HASH_BITS` bits of the bit-reversed Ethernet CRC-32 of the six address bytes. The CRC is preset to all ones, takes each byte least-significant bit first with the reflected polynomial 0xEDB88320, and its final value is complemented.
- R2: Hash word `w` is written at word address `2*NUM_ENTRIES + w`. The index bits above bit 4 select the word, and index bits [4:0] select the bit in it. With hash filtering on, a group address whose bin bit is 1 passes with reason code 5 (hash).
- R3: Entry `i` is loaded through two word addresses:
  - at `2*i`, address bytes 0..3, with byte 0 in bits [7:0];
  - at `2*i+1`, bytes 4..5 in bits [15:0].
  
  A unicast address equal to a nonzero entry passes with reason 4 (perfect). A group address equal to a nonzero entry passes the same way, unless hash filtering is on without hash-or-perfect. A unicast address with no match and no other pass is dropped with reason 0.
- R4: An entry holding all zeros never matches, including against the all-zero address.
- R5: In promiscuous mode every frame passes with reason 1.
- R6: With pass-all-multicast set, every group address passes with reason 3, unless a higher-priority reason applies. An address is a group address when bit 0 of its first byte is 1. Broadcast dropped by R8 is the one exception.
- R7: In hash-or-perfect mode, a unicast address also passes on a set hash bin. A group address under hash filtering also passes on an exact entry match. Reason priority is promiscuous (1), broadcast (2), perfect (4), all-multicast (3), hash (5).
- R8: The all-ones address passes with reason 2 unless broadcast drop is set. With broadcast drop set it is dropped, reason 0, unless promiscuous mode is on.
- R9: `dec_pass` is 1 exactly when the reason is nonzero. `dec_accept` equals `dec_pass`, except in receive-all mode, where it is 1 while `dec_pass` still reports the filter result.
- R10: `dec_valid` is a one-cycle pulse in the cycle after the sixth address byte is taken, and only then. A byte with `s_sof` high is byte 0 and restarts the address. Bytes after the sixth, and bytes arriving after reset before any `s_sof`, are ignored.
- R11: `s_ready` is 1 in every cycle, and an address byte is counted only in a cycle with `s_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_valid | input | 1 | Address byte present |
| s_ready | output | 1 | Always 1, no back-pressure |
| s_sof | input | 1 | Marks byte 0 of a frame |
| s_data | input | 8 | Frame byte |
| cfg_promisc | input | 1 | Pass every frame |
| cfg_pass_mcast | input | 1 | Pass every group address |
| cfg_hash_mcast | input | 1 | Filter group addresses through the hash table |
| cfg_hash_or_perfect | input | 1 | Pass on either hash or exact match |
| cfg_rx_all | input | 1 | Accept every frame, still report the filter result |
| cfg_bcast_drop | input | 1 | Drop broadcast unless promiscuous |
| wr_en | input | 1 | Table word write strobe |
| wr_addr | input | ADDR_W | Table word address |
| wr_data | input | 32 | Table word data |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | Frame is to be kept |
| dec_pass | output | 1 | Address filter result |
| dec_reason | output | 3 | Pass reason code (0 none) |
| dec_hash_idx | output | HASH_BITS | Multicast bin index of the address |

## Verification
The assertions check on every decision:
- the single-cycle strobe that follows a taken byte;
- promiscuous and receive-all acceptance;
- the link between the pass flag and the reason code;
- broadcast handling, and passing of group addresses under pass-all-multicast;
- that an all-zero address never yields a perfect match.

Only the bench can show the bin index against an independent CRC-32 for all three table sizes. The same holds for the word and bit layout of the hash table and the byte order of the entry writes. It also shows the priority among competing reasons, and the restart, gap and extra-byte cases of the byte stream.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;
  localparam int DA_BYTES = 6;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;

  typedef enum logic [2:0] {
    RSN_NONE    = 3'd0,
    RSN_PROMISC = 3'd1,
    RSN_BCAST   = 3'd2,
    RSN_ALLMC   = 3'd3,
    RSN_PERFECT = 3'd4,
    RSN_HASH    = 3'd5
  } reason_e;
endpackage

// File: rtl/rxaf_crc.sv
module rxaf_crc
  import rxaf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        restart,
  input  logic [7:0]  data,
  output logic [31:0] crc_q
);
  logic [31:0] crc_d;

  // byte-serial reflected CRC: eight bit steps unrolled per cycle
  always_comb begin
    crc_d = restart ? 32'hFFFF_FFFF : crc_q;
    for (int b = 0; b < 8; b++) begin
      if (crc_d[0] ^ data[b]) crc_d = (crc_d >> 1) ^ CRC_POLY_REFL;
      else                    crc_d = crc_d >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  crc_q <= 32'hFFFF_FFFF;
    else if (en) crc_q <= crc_d;
  end
endmodule

// File: rtl/rxaf_perfect.sv
module rxaf_perfect #(
  parameter int NUM_ENTRIES = 4,
  parameter int ADDR_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [47:0]       da,
  output logic              hit
);
  logic [NUM_ENTRIES-1:0] match;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    logic [31:0] lo_q;
    logic [15:0] hi_q;
    logic [47:0] ent;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q <= '0;
        hi_q <= '0;
      end else if (wr_en) begin
        if (wr_addr == ADDR_W'(2*i))   lo_q <= wr_data;
        if (wr_addr == ADDR_W'(2*i+1)) hi_q <= wr_data[15:0];
      end
    end

    assign ent      = {hi_q, lo_q};
    assign match[i] = (ent != '0) && (ent == da);
  end

  assign hit = |match;
endmodule

// File: rtl/rxaf_hash_tbl.sv
module rxaf_hash_tbl #(
  parameter int HASH_BITS = 6,
  parameter int ADDR_W    = 4,
  parameter int BASE      = 8,
  localparam int WORDS    = 1 << (HASH_BITS - 5)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [31:0]          wr_data,
  input  logic [HASH_BITS-1:0] idx,
  output logic                 hit
);
  logic [WORDS-1:0][31:0] words_q;
  logic [31:0]            sel;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        words_q[w] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(BASE + w))
        words_q[w] <= wr_data;
    end
  end

  assign sel = words_q[idx[HASH_BITS-1:5]];
  assign hit = sel[idx[4:0]];
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxaf_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int HASH_BITS   = 6,
  localparam int HASH_WORDS = 1 << (HASH_BITS - 5),
  localparam int ADDR_W     = $clog2(2*NUM_ENTRIES + HASH_WORDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic                 s_sof,
  input  logic [7:0]           s_data,
  input  logic                 cfg_promisc,
  input  logic                 cfg_pass_mcast,
  input  logic                 cfg_hash_mcast,
  input  logic                 cfg_hash_or_perfect,
  input  logic                 cfg_rx_all,
  input  logic                 cfg_bcast_drop,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [31:0]          wr_data,
  output logic                 dec_valid,
  output logic                 dec_accept,
  output logic                 dec_pass,
  output logic [2:0]           dec_reason,
  output logic [HASH_BITS-1:0] dec_hash_idx
);
  localparam logic [2:0] CNT_IDLE = 3'(DA_BYTES);

  logic [2:0]  cnt_q, pos;
  logic        take, fin_q;
  logic [47:0] da_q;
  logic [31:0] crc_q, crc_fin;
  logic        hash_hit, perf_hit;
  logic        is_mc, is_bc, perf_ok, hash_ok, allmc_ok;
  reason_e     reason;

  assign s_ready = 1'b1;
  assign pos     = s_sof ? 3'd0 : cnt_q;
  assign take    = s_valid && (s_sof || cnt_q != CNT_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_IDLE;
      fin_q <= 1'b0;
      da_q  <= '0;
    end else begin
      fin_q <= take && (pos == CNT_IDLE - 3'd1);
      if (take) begin
        cnt_q                  <= pos + 3'd1;
        da_q[{pos, 3'b000} +: 8] <= s_data;
      end
    end
  end

  rxaf_crc u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (take),
    .restart (pos == 3'd0),
    .data    (s_data),
    .crc_q   (crc_q)
  );

  assign crc_fin = ~crc_q;
  for (genvar i = 0; i < HASH_BITS; i++) begin : g_idx
    assign dec_hash_idx[HASH_BITS-1-i] = crc_fin[i];
  end

  rxaf_hash_tbl #(.HASH_BITS(HASH_BITS), .ADDR_W(ADDR_W), .BASE(2*NUM_ENTRIES)) u_hash (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .idx     (dec_hash_idx),
    .hit     (hash_hit)
  );

  rxaf_perfect #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_perf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .da      (da_q),
    .hit     (perf_hit)
  );

  assign is_mc    = da_q[0];
  assign is_bc    = &da_q;
  assign perf_ok  = perf_hit && (!is_mc || !cfg_hash_mcast || cfg_hash_or_perfect);
  assign hash_ok  = hash_hit && ((is_mc && cfg_hash_mcast) || (!is_mc && cfg_hash_or_perfect));
  assign allmc_ok = is_mc && cfg_pass_mcast;

  always_comb begin
    if (cfg_promisc)   reason = RSN_PROMISC;
    else if (is_bc)    reason = cfg_bcast_drop ? RSN_NONE : RSN_BCAST;
    else if (perf_ok)  reason = RSN_PERFECT;
    else if (allmc_ok) reason = RSN_ALLMC;
    else if (hash_ok)  reason = RSN_HASH;
    else               reason = RSN_NONE;
  end

  assign dec_valid  = fin_q;
  assign dec_reason = reason;
  assign dec_pass   = (reason != RSN_NONE);
  assign dec_accept = dec_pass || cfg_rx_all;
endmodule

// File: rtl/rxaf_chk.sv
module rxaf_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        s_valid,
  input logic        cfg_promisc,
  input logic        cfg_pass_mcast,
  input logic        cfg_rx_all,
  input logic        cfg_bcast_drop,
  input logic        dec_valid,
  input logic        dec_accept,
  input logic        dec_pass,
  input logic [2:0]  dec_reason,
  input logic [47:0] da
);
  // R10
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);

  // R10
  after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(s_valid));

  // R5
  promisc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && cfg_promisc) |-> (dec_pass && dec_reason == 3'd1));

  // R9
  rx_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && cfg_rx_all) |-> dec_accept);

  // R9
  accept_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !cfg_rx_all) |-> (dec_accept == dec_pass));

  // R9
  reason_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (dec_pass == (dec_reason != 3'd0)));

  // R6
  allmc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && cfg_pass_mcast && da[0] && !(da == '1 && cfg_bcast_drop)) |-> dec_pass);

  // R8
  bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && da == '1 && !cfg_promisc) |-> (dec_reason == (cfg_bcast_drop ? 3'd0 : 3'd2)));

  // R4
  zero_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && da == '0) |-> (dec_reason != 3'd4));
endmodule

bind rx_addr_filter rxaf_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .s_valid        (s_valid),
  .cfg_promisc    (cfg_promisc),
  .cfg_pass_mcast (cfg_pass_mcast),
  .cfg_rx_all     (cfg_rx_all),
  .cfg_bcast_drop (cfg_bcast_drop),
  .dec_valid      (dec_valid),
  .dec_accept     (dec_accept),
  .dec_pass       (dec_pass),
  .dec_reason     (dec_reason),
  .da             (da_q)
);

// File: tb/sim_rx_addr_filter.sv
`timescale 1ns/1ps
module sim_rx_addr_filter;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, s_valid, s_sof;
  logic [7:0]  s_data;
  logic [5:0]  cfg;   // [5]promisc [4]pass_mc [3]hash_mc [2]hop [1]rx_all [0]bcast_drop
  logic [2:0]  wen;
  logic [3:0]  wr_addr;
  logic [31:0] wr_data;
  logic [2:0]  rdy, vld, acc, pas;
  logic [2:0]  rsn [3];
  logic [5:0]  idx0;
  logic [6:0]  idx1;
  logic [7:0]  idx2;

  int checks = 0, failures = 0;
  logic [47:0] ent [4];
  bit hb [3][256];

  rx_addr_filter #(.NUM_ENTRIES(4), .HASH_BITS(6)) u0 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(rdy[0]), .s_sof(s_sof), .s_data(s_data),
    .cfg_promisc(cfg[5]), .cfg_pass_mcast(cfg[4]), .cfg_hash_mcast(cfg[3]),
    .cfg_hash_or_perfect(cfg[2]), .cfg_rx_all(cfg[1]), .cfg_bcast_drop(cfg[0]),
    .wr_en(wen[0]), .wr_addr(wr_addr), .wr_data(wr_data),
    .dec_valid(vld[0]), .dec_accept(acc[0]), .dec_pass(pas[0]), .dec_reason(rsn[0]), .dec_hash_idx(idx0));
  rx_addr_filter #(.NUM_ENTRIES(4), .HASH_BITS(7)) u1 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(rdy[1]), .s_sof(s_sof), .s_data(s_data),
    .cfg_promisc(cfg[5]), .cfg_pass_mcast(cfg[4]), .cfg_hash_mcast(cfg[3]),
    .cfg_hash_or_perfect(cfg[2]), .cfg_rx_all(cfg[1]), .cfg_bcast_drop(cfg[0]),
    .wr_en(wen[1]), .wr_addr(wr_addr), .wr_data(wr_data),
    .dec_valid(vld[1]), .dec_accept(acc[1]), .dec_pass(pas[1]), .dec_reason(rsn[1]), .dec_hash_idx(idx1));
  rx_addr_filter #(.NUM_ENTRIES(4), .HASH_BITS(8)) u2 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(rdy[2]), .s_sof(s_sof), .s_data(s_data),
    .cfg_promisc(cfg[5]), .cfg_pass_mcast(cfg[4]), .cfg_hash_mcast(cfg[3]),
    .cfg_hash_or_perfect(cfg[2]), .cfg_rx_all(cfg[1]), .cfg_bcast_drop(cfg[0]),
    .wr_en(wen[2]), .wr_addr(wr_addr), .wr_data(wr_data),
    .dec_valid(vld[2]), .dec_accept(acc[2]), .dec_pass(pas[2]), .dec_reason(rsn[2]), .dec_hash_idx(idx2));

  localparam logic [47:0] U0 = 48'h00_11_22_33_44_55;
  localparam logic [47:0] M1 = 48'h01_00_5E_00_00_01;
  localparam logic [47:0] UH = 48'h00_AA_BB_CC_DD_EE;
  localparam logic [47:0] MH = 48'h01_00_5E_7F_00_0A;
  localparam logic [47:0] UX = 48'h00_DE_AD_BE_EF_01;
  localparam logic [47:0] MX = 48'h33_33_00_00_00_16;
  localparam logic [47:0] BC = 48'hFF_FF_FF_FF_FF_FF;
  localparam logic [47:0] ZZ = 48'h0;

  localparam int NV = 20;
  localparam logic [53:0] VEC [NV] = '{
    {U0, 6'h00}, {UX, 6'h00}, {M1, 6'h00}, {MX, 6'h00}, {BC, 6'h00},
    {BC, 6'h01}, {ZZ, 6'h00}, {MH, 6'h08}, {MX, 6'h08}, {M1, 6'h08},
    {M1, 6'h0C}, {UH, 6'h00}, {UH, 6'h04}, {UX, 6'h20}, {MX, 6'h10},
    {UX, 6'h02}, {BC, 6'h21}, {MH, 6'h18}, {U0, 6'h22}, {MX, 6'h12}
  };

  // wire order: byte 0 sits in [47:40]
  function automatic logic [31:0] ref_crc(input logic [47:0] da);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++) begin
      logic [7:0] b = da[47-8*k -: 8];
      for (int i = 0; i < 8; i++)
        c = (c[0] ^ b[i]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  function automatic int ref_idx(input logic [47:0] da, input int n);
    logic [31:0] c = ref_crc(da);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[31-i] = c[i];
    return int'(r >> (32 - n));
  endfunction

  function automatic int model(input logic [47:0] da, input logic [5:0] c, input int inst);
    bit mc = da[40];
    bit bc = (da == BC);
    bit ph = 0;
    bit hh = hb[inst][ref_idx(da, 6 + inst)];
    for (int i = 0; i < 4; i++) if (ent[i] != 0 && ent[i] == da) ph = 1;
    if (c[5]) return 1;
    if (bc) return c[0] ? 0 : 2;
    if (ph && (!mc || !c[3] || c[2])) return 4;
    if (mc && c[4]) return 3;
    if (hh && ((mc && c[3]) || (!mc && c[2]))) return 5;
    return 0;
  endfunction

  function automatic string tag_of(input int r, input logic [5:0] c);
    case (r)
      1: return "R5";
      2: return "R8";
      3: return "R6";
      4: return c[2] ? "R7" : "R3";
      5: return c[2] ? "R7" : "R2";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(input int act, input int exp, input string req, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] m, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wen = m; wr_addr = a; wr_data = d;
    @(negedge clk);
    wen = '0;
  endtask

  task automatic load_entry(input int i, input logic [47:0] da);
    wr(3'b111, 4'(2*i), {da[23:16], da[31:24], da[39:32], da[47:40]});
    wr(3'b111, 4'(2*i+1), {16'h0, da[7:0], da[15:8]});
    ent[i] = da;
  endtask

  task automatic set_bin(input int inst, input int ix);
    logic [31:0] d;
    int w = ix >> 5;
    hb[inst][ix] = 1;
    for (int j = 0; j < 32; j++) d[j] = hb[inst][w*32 + j];
    wr(3'(1 << inst), 4'(8 + w), d);
  endtask

  task automatic drive_byte(input logic sof, input logic [7:0] b);
    @(negedge clk);
    s_valid = 1'b1; s_sof = sof; s_data = b;
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    s_valid = 1'b0; s_sof = 1'b0;
  endtask

  task automatic check_decision(input logic [47:0] da);
    for (int n = 0; n < 3; n++) begin
      int e = model(da, cfg, n);
      int ix = (n == 0) ? int'(idx0) : (n == 1) ? int'(idx1) : int'(idx2);
      chk(int'(vld[n]), 1, "R10", "valid after sixth byte");
      chk(ix, ref_idx(da, 6 + n), "R1", "hash index");
      chk(int'(rsn[n]), e, tag_of(e, cfg), "reason");
      chk(int'(pas[n]), (e != 0) ? 1 : 0, "R9", "pass flag");
      chk(int'(acc[n]), (e != 0 || cfg[1]) ? 1 : 0, "R9", "accept");
    end
  endtask

  // six bytes back to back, decision sampled one cycle after the last
  task automatic send_frame(input logic [47:0] da);
    for (int k = 0; k < 6; k++) drive_byte(k == 0, da[47-8*k -: 8]);
    idle_cycle();
    check_decision(da);
    idle_cycle();
    chk(int'(vld[0]), 0, "R10", "pulse lasts one cycle");
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; s_valid = 1'b0; s_sof = 1'b0; s_data = '0;
    cfg = '0; wen = '0; wr_addr = '0; wr_data = '0;
    for (int i = 0; i < 4; i++) ent[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(int'(vld), 0, "R10", "no decision after reset");
    chk(int'(rdy), 7, "R11", "ready high");

    // R10: bytes before any start-of-frame are ignored
    for (int k = 0; k < 6; k++) drive_byte(1'b0, 8'hAA);
    idle_cycle();
    chk(int'(vld), 0, "R10", "no decision without sof");

    load_entry(0, U0);
    load_entry(1, M1);
    for (int n = 0; n < 3; n++) begin
      set_bin(n, ref_idx(MH, 6 + n));
      set_bin(n, ref_idx(UH, 6 + n));
    end

    for (int v = 0; v < NV; v++) begin
      cfg = VEC[v][5:0];
      send_frame(VEC[v][53:6]);
    end

    // R4: entry loaded and cleared back to zero matches nothing
    cfg = 6'h00;
    load_entry(2, UX);
    send_frame(UX);
    load_entry(2, ZZ);
    send_frame(UX);
    send_frame(ZZ);

    // R11/R10: gaps with s_valid low inside the address
    for (int k = 0; k < 3; k++) drive_byte(k == 0, U0[47-8*k -: 8]);
    idle_cycle(); idle_cycle();
    drive_byte(1'b0, U0[23:16]);
    drive_byte(1'b0, U0[15:8]);
    idle_cycle();
    chk(int'(vld[0]), 0, "R11", "five bytes give no decision");
    drive_byte(1'b0, U0[7:0]);
    idle_cycle();
    check_decision(U0);

    // R10: bytes after the sixth give no second decision
    for (int k = 0; k < 4; k++) begin
      drive_byte(1'b0, 8'h5A);
      chk(int'(vld[0]), 0, "R10", "trailing bytes ignored");
    end
    idle_cycle();
    chk(int'(vld[0]), 0, "R10", "trailing bytes ignored");

    // R10: sof in the middle of an address restarts it
    for (int k = 0; k < 3; k++) drive_byte(k == 0, UX[47-8*k -: 8]);
    for (int k = 0; k < 6; k++) drive_byte(k == 0, U0[47-8*k -: 8]);
    idle_cycle();
    check_decision(U0);

    // R1: random addresses, all three table sizes
    cfg = 6'h08;
    for (int t = 0; t < 24; t++) begin
      logic [47:0] da = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      send_frame(da);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule